// File: doc/BRIEF.md
# Ternary Comb and Biquad Stream Filter

This block filters a stream of 16-bit two's complement samples through two sections in series. The first is a feed-forward comb that subtracts a signed, programmable-delay copy of the input from the input itself. The second is a second-order section with two feed-forward taps and two feedback taps. Every coefficient is restricted to -1, 0 or +1, so each product becomes a pass, a negate or a zero, and no multiplier is needed. The transfer function is (1 − c·z^-N)·(b0 + b1·z^-1 + b2·z^-2) / (1/a0 − a1·z^-1 − a2·z^-2). Because a0 is ±1, 1/a0 equals a0, and the recursion becomes y[n] = a0·(w[n] + a1·y[n−1] + a2·y[n−2]), where w is the feed-forward result.

The coefficients and the comb delay are static configuration inputs, changed only while reset is held. Choosing them turns the block into a first differencer, a running-sum integrator, a comb or a simple resonator. Samples enter with a valid strobe and leave with a valid strobe a fixed two cycles later. The block has two registered stages: a feed-forward stage and a recursive stage. The recursive stage sorts its result into one of three saturation classes: none, high or low.

Top module: `tern_cbq_filter`

## Requirements
- R1: Each coefficient is a 2-bit code. Bit 1 is the sign and bit 0 is the magnitude. Code 01 means +1 and code 11 means -1. Codes 00 and 10 both mean 0.
- R2: The comb stage computes v[n] = x[n] − c·x[n−N], where N is the 5-bit delay input. When N is 0, the current sample is used as the delayed term. When c is zero, v equals x.
- R3: The feed-forward result is w[n] = b0·v[n] + b1·v[n−1] + b2·v[n−2].
- R4: The output is y[n] = a0·(w[n] + a1·y[n−1] + a2·y[n−2]). An a0 code meaning zero is treated as +1.
- R5: The output saturates to the range [-32768, 32767] instead of wrapping. The feedback history holds the saturated value.
- R6: Each sample accepted with in_valid high produces exactly one out_valid pulse two cycles later. out_valid is low in every other cycle.
- R7: The delay line and all history registers advance only on valid samples. in_sample is ignored while in_valid is low, and out_sample holds its value between output pulses.
- R8: A synchronous reset clears the delay line and all history to zero. It also drives out_valid and out_sample to zero.
- R9: With a0=+1, b0=+1, b1=-1 and all other coefficients 0, the block is a first differencer. With a0=+1, a1=+1, b0=+1 and all other coefficients 0, it is an integrator. With c=+1, N=8, a0=+1, b0=+1 and all other coefficients 0, it outputs x[n] − x[n−8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Input sample, two's complement |
| comb_delay | input | 5 | Comb delay N, 0 to 31 |
| c_code | input | 2 | Comb coefficient code |
| b0_code | input | 2 | Feed-forward tap 0 code |
| b1_code | input | 2 | Feed-forward tap 1 code |
| b2_code | input | 2 | Feed-forward tap 2 code |
| a0_code | input | 2 | Output scale code |
| a1_code | input | 2 | Feedback tap 1 code |
| a2_code | input | 2 | Feedback tap 2 code |
| out_valid | output | 1 | Output sample strobe |
| out_sample | output | 16 | Filtered sample, saturated |

## Verification
The hardest situation to reach is a long delay tap or a saturated feedback value that is read while valid gaps are interleaved. In that case, the history seen by the filter differs from a cycle-indexed history. The bench sweeps every ternary combination of the seven coefficients, with the delay tied to the combination index. It sends bursts that have random valid gaps, garbage sample values during the gaps, and full-scale samples mixed in. The negative-zero code is substituted for zero on alternating combinations. Directed runs then drive a 31-sample delay, an integrator pushed into both rails, and a reset in mid-stream.

// File: rtl/tcbq_pkg.sv
`timescale 1ns/1ps
package tcbq_pkg;

    // Ternary coefficient value after decoding
    typedef enum logic [1:0] {
        TERN_ZERO = 2'd0,
        TERN_POS  = 2'd1,
        TERN_NEG  = 2'd2
    } tern_e;

    // Saturation class of the recursive result
    typedef enum logic [1:0] {
        SAT_NONE = 2'd0,
        SAT_HIGH = 2'd1,
        SAT_LOW  = 2'd2
    } sat_e;

    // Bit 1 = sign, bit 0 = magnitude; a clear magnitude is zero whatever the sign
    function automatic tern_e tern_decode(input logic [1:0] code);
        if (!code[0]) begin
            return TERN_ZERO;
        end else if (code[1]) begin
            return TERN_NEG;
        end
        return TERN_POS;
    endfunction

endpackage

// File: rtl/tcbq_comb.sv
`timescale 1ns/1ps
module tcbq_comb
    import tcbq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       advance,
    input  logic signed [SAMPLE_W-1:0] x,
    input  logic        [DELAY_W-1:0]  delay,
    input  tern_e                      c_t,
    output logic signed [SAMPLE_W:0]   v
);
    localparam int DEPTH = (1 << DELAY_W) - 1;

    logic signed [SAMPLE_W-1:0] tap [DEPTH];
    logic signed [SAMPLE_W-1:0] xd;
    logic signed [SAMPLE_W:0]   x_ext;
    logic signed [SAMPLE_W:0]   xd_ext;

    // Delay line: tap[k] holds the sample k+1 valid steps back
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) begin
                tap[k] <= '0;
            end
        end else if (advance) begin
            tap[0] <= x;
            for (int k = 1; k < DEPTH; k++) begin
                tap[k] <= tap[k-1];
            end
        end
    end

    always_comb begin
        if (delay == '0) begin
            xd = x;
        end else begin
            xd = tap[delay - 1'b1];
        end
    end

    assign x_ext  = {x[SAMPLE_W-1], x};
    assign xd_ext = {xd[SAMPLE_W-1], xd};

    always_comb begin
        case (c_t)
            TERN_POS: v = x_ext - xd_ext;
            TERN_NEG: v = x_ext + xd_ext;
            default:  v = x_ext;
        endcase
    end
endmodule

// File: rtl/tcbq_fir.sv
`timescale 1ns/1ps
module tcbq_fir
    import tcbq_pkg::*;
#(
    parameter int IN_W  = 17,
    parameter int ACC_W = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  v,
    input  tern_e                   b0_t,
    input  tern_e                   b1_t,
    input  tern_e                   b2_t,
    output logic                    w_valid,
    output logic signed [ACC_W-1:0] w
);
    localparam int EXT_W = ACC_W - IN_W;

    logic signed [IN_W-1:0]  v1;
    logic signed [IN_W-1:0]  v2;
    logic signed [ACC_W-1:0] sum;

    function automatic logic signed [ACC_W-1:0] term(input tern_e t,
                                                     input logic signed [IN_W-1:0] s);
        logic signed [ACC_W-1:0] e;
        e = {{EXT_W{s[IN_W-1]}}, s};
        case (t)
            TERN_POS: return e;
            TERN_NEG: return -e;
            default:  return '0;
        endcase
    endfunction

    assign sum = term(b0_t, v) + term(b1_t, v1) + term(b2_t, v2);

    always_ff @(posedge clk) begin
        if (rst) begin
            w_valid <= 1'b0;
            w       <= '0;
            v1      <= '0;
            v2      <= '0;
        end else begin
            w_valid <= in_valid;
            if (in_valid) begin
                w  <= sum;
                v1 <= v;
                v2 <= v1;
            end
        end
    end
endmodule

// File: rtl/tcbq_iir.sv
`timescale 1ns/1ps
module tcbq_iir
    import tcbq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       w_valid,
    input  logic signed [ACC_W-1:0]    w,
    input  tern_e                      a0_t,
    input  tern_e                      a1_t,
    input  tern_e                      a2_t,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_sample,
    output logic signed [ACC_W-1:0]    acc
);
    localparam int EXT_W = ACC_W - SAMPLE_W;
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - 1;

    logic signed [SAMPLE_W-1:0] y2;
    logic signed [ACC_W-1:0]    fb_sum;
    logic signed [SAMPLE_W-1:0] y_next;
    sat_e                       sat_cls;

    function automatic logic signed [ACC_W-1:0] term(input tern_e t,
                                                     input logic signed [SAMPLE_W-1:0] s);
        logic signed [ACC_W-1:0] e;
        e = {{EXT_W{s[SAMPLE_W-1]}}, s};
        case (t)
            TERN_POS: return e;
            TERN_NEG: return -e;
            default:  return '0;
        endcase
    endfunction

    // out_sample doubles as the y[n-1] history register
    assign fb_sum = w + term(a1_t, out_sample) + term(a2_t, y2);
    // a0 of zero is taken as +1, so only a negative a0 flips the sign
    assign acc    = (a0_t == TERN_NEG) ? -fb_sum : fb_sum;

    always_comb begin
        if (acc > Y_MAX) begin
            sat_cls = SAT_HIGH;
        end else if (acc < Y_MIN) begin
            sat_cls = SAT_LOW;
        end else begin
            sat_cls = SAT_NONE;
        end
    end

    always_comb begin
        case (sat_cls)
            SAT_HIGH: y_next = Y_MAX[SAMPLE_W-1:0];
            SAT_LOW:  y_next = Y_MIN[SAMPLE_W-1:0];
            default:  y_next = acc[SAMPLE_W-1:0];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
            y2         <= '0;
        end else begin
            out_valid <= w_valid;
            if (w_valid) begin
                out_sample <= y_next;
                y2         <= out_sample;
            end
        end
    end
endmodule

// File: rtl/tern_cbq_filter.sv
`timescale 1ns/1ps
module tern_cbq_filter
    import tcbq_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 20,
    parameter int DELAY_W  = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_sample,
    input  logic [DELAY_W-1:0]  comb_delay,
    input  logic [1:0]          c_code,
    input  logic [1:0]          b0_code,
    input  logic [1:0]          b1_code,
    input  logic [1:0]          b2_code,
    input  logic [1:0]          a0_code,
    input  logic [1:0]          a1_code,
    input  logic [1:0]          a2_code,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_sample
);
    localparam int V_W = SAMPLE_W + 1;

    tern_e                      c_t, b0_t, b1_t, b2_t, a0_t, a1_t, a2_t;
    logic signed [V_W-1:0]      comb_v;
    logic                       w_valid;
    logic signed [ACC_W-1:0]    w;
    logic signed [ACC_W-1:0]    iir_acc;
    logic signed [SAMPLE_W-1:0] y_s;

    assign c_t  = tern_decode(c_code);
    assign b0_t = tern_decode(b0_code);
    assign b1_t = tern_decode(b1_code);
    assign b2_t = tern_decode(b2_code);
    assign a0_t = tern_decode(a0_code);
    assign a1_t = tern_decode(a1_code);
    assign a2_t = tern_decode(a2_code);

    tcbq_comb #(.SAMPLE_W(SAMPLE_W), .DELAY_W(DELAY_W)) i_comb (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .x       ($signed(in_sample)),
        .delay   (comb_delay),
        .c_t     (c_t),
        .v       (comb_v)
    );

    tcbq_fir #(.IN_W(V_W), .ACC_W(ACC_W)) i_fir (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .v        (comb_v),
        .b0_t     (b0_t),
        .b1_t     (b1_t),
        .b2_t     (b2_t),
        .w_valid  (w_valid),
        .w        (w)
    );

    tcbq_iir #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) i_iir (
        .clk        (clk),
        .rst        (rst),
        .w_valid    (w_valid),
        .w          (w),
        .a0_t       (a0_t),
        .a1_t       (a1_t),
        .a2_t       (a2_t),
        .out_valid  (out_valid),
        .out_sample (y_s),
        .acc        (iir_acc)
    );

    assign out_sample = y_s;
endmodule

// File: rtl/tcbq_checker.sv
`timescale 1ns/1ps
module tcbq_checker #(
    parameter int SAMPLE_W = 16,
    parameter int ACC_W    = 20
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic [SAMPLE_W-1:0] in_sample,
    input logic [1:0]          c_code,
    input logic [SAMPLE_W:0]   comb_v,
    input logic                w_valid,
    input logic [ACC_W-1:0]    iir_acc,
    input logic                out_valid,
    input logic [SAMPLE_W-1:0] out_sample
);
    localparam logic signed [ACC_W-1:0] Y_MAX = ACC_W'((1 << (SAMPLE_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] Y_MIN = -Y_MAX - 1;

    assert_valid_latency_R6: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);

    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> (!out_valid && out_sample == '0));

    assert_output_held_R7: assert property (@(posedge clk) disable iff (rst)
        !w_valid |=> $stable(out_sample));

    assert_comb_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
        !c_code[0] |-> comb_v == {in_sample[SAMPLE_W-1], in_sample});

    assert_sat_high_R5: assert property (@(posedge clk) disable iff (rst)
        (w_valid && $signed(iir_acc) > Y_MAX) |=> out_sample == Y_MAX[SAMPLE_W-1:0]);

    assert_sat_low_R5: assert property (@(posedge clk) disable iff (rst)
        (w_valid && $signed(iir_acc) < Y_MIN) |=> out_sample == Y_MIN[SAMPLE_W-1:0]);
endmodule

bind tern_cbq_filter tcbq_checker #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) i_tcbq_checker (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sample  (in_sample),
    .c_code     (c_code),
    .comb_v     (comb_v),
    .w_valid    (w_valid),
    .iir_acc    (iir_acc),
    .out_valid  (out_valid),
    .out_sample (out_sample)
);

// File: tb/test_tern_cbq_filter.sv
`timescale 1ns/1ps
module test_tern_cbq_filter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic [4:0]  comb_delay = '0;
    logic [1:0]  c_code = '0, b0_code = '0, b1_code = '0, b2_code = '0;
    logic [1:0]  a0_code = '0, a1_code = '0, a2_code = '0;
    logic        out_valid;
    logic [15:0] out_sample;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [31:0] rng = 32'h1234_5678;
    string cur_tag = "R3/R4 sweep";

    // reference model state
    int mx [0:31];
    int mv1, mv2, my1, my2;
    int exp_val [0:63];
    int exp_cyc [0:63];
    int wp = 0, rp = 0;

    tern_cbq_filter i_tern_cbq_filter (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .comb_delay(comb_delay), .c_code(c_code), .b0_code(b0_code),
        .b1_code(b1_code), .b2_code(b2_code), .a0_code(a0_code),
        .a1_code(a1_code), .a2_code(a2_code),
        .out_valid(out_valid), .out_sample(out_sample)
    );

    always #2.5 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    function automatic int tval(input logic [1:0] code);
        if (!code[0]) return 0;
        return code[1] ? -1 : 1;
    endfunction

    function automatic int clamp16(input int s);
        if (s > 32767) return 32767;
        if (s < -32768) return -32768;
        return s;
    endfunction

    task automatic step_rng();
        rng ^= rng << 13;
        rng ^= rng >> 17;
        rng ^= rng << 5;
    endtask

    task automatic gen_sample(output int x);
        step_rng();
        case (rng[3:0])
            4'd0:    x = 32767;
            4'd1:    x = -32768;
            default: x = int'($signed(rng[31:16]));
        endcase
    endtask

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mx[i] = 0;
        mv1 = 0; mv2 = 0; my1 = 0; my2 = 0;
    endtask

    task automatic model_push(input int x, input int due);
        int xd, v, w, s, a0e, y;
        xd = (comb_delay == 0) ? x : mx[comb_delay - 1];
        v  = x - tval(c_code) * xd;
        w  = tval(b0_code) * v + tval(b1_code) * mv1 + tval(b2_code) * mv2;
        s  = w + tval(a1_code) * my1 + tval(a2_code) * my2;
        a0e = (tval(a0_code) == 0) ? 1 : tval(a0_code);
        y  = clamp16(a0e * s);
        for (int i = 31; i > 0; i--) mx[i] = mx[i-1];
        mx[0] = x;
        mv2 = mv1; mv1 = v;
        my2 = my1; my1 = y;
        exp_val[wp % 64] = y;
        exp_cyc[wp % 64] = due;
        wp++;
    endtask

    // drive one cycle; when valid, the result is due two edges later
    task automatic drive(input logic v, input int x);
        @(posedge clk);
        #1;
        in_valid = v;
        if (v) begin
            in_sample = x[15:0];
            model_push(x, cyc + 2);
        end else begin
            step_rng();
            in_sample = rng[23:8];
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 0);
    endtask

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, expv);
        end
    endtask

    // output monitor, sampled away from the active edge
    initial forever begin
        @(negedge clk);
        if (!rst) begin
            if (out_valid) begin
                if (rp == wp) begin
                    check("R6 unexpected out_valid", 1, 0);
                end else begin
                    check("R6 output cycle", cyc, exp_cyc[rp % 64]);
                    check(cur_tag, int'($signed(out_sample)), exp_val[rp % 64]);
                    rp++;
                end
            end else if (rp != wp && exp_cyc[rp % 64] <= cyc) begin
                check("R6 missing output", 0, 1);
                rp++;
            end
        end
    end

    task automatic do_reset(input logic [4:0] n, input logic [1:0] c, input logic [1:0] b0,
                            input logic [1:0] b1, input logic [1:0] b2, input logic [1:0] a0,
                            input logic [1:0] a1, input logic [1:0] a2);
        @(posedge clk);
        #1;
        rst = 1'b1;
        in_valid = 1'b0;
        comb_delay = n; c_code = c; b0_code = b0; b1_code = b1; b2_code = b2;
        a0_code = a0; a1_code = a1; a2_code = a2;
        @(posedge clk);
        @(negedge clk);
        check("R8 reset out_valid", int'(out_valid), 0);
        check("R8 reset out_sample", int'(out_sample), 0);
        rp = 0; wp = 0;
        model_reset();
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic burst(input int n, input logic gaps);
        int x;
        for (int i = 0; i < n; i++) begin
            gen_sample(x);
            step_rng();
            drive(gaps ? rng[9] | rng[10] : 1'b1, x);
        end
        idle(3);
        check({cur_tag, " drained"}, wp - rp, 0);
    endtask

    initial begin
        int done;
        done = 0;
        fork
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    check("watchdog", 1, 0);
                    $display("Result: errors=%0d of %0d checks", errors, checks);
                    $finish;
                end
            end
        join_none

        model_reset();
        repeat (2) @(posedge clk);

        // R9 differencer: y = x[n] - x[n-1]
        cur_tag = "R9 differencer";
        do_reset(5'd0, 2'b00, 2'b01, 2'b11, 2'b00, 2'b01, 2'b00, 2'b00);
        drive(1'b1, 100);
        drive(1'b1, 250);
        drive(1'b1, -50);
        drive(1'b0, 7);
        drive(1'b1, -50);
        idle(3);
        burst(20, 1'b1);

        // R9 integrator, then R5 both rails
        cur_tag = "R9 integrator";
        do_reset(5'd0, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b01, 2'b00);
        for (int i = 1; i <= 6; i++) drive(1'b1, i * 3);
        idle(3);
        cur_tag = "R5 saturate high";
        for (int i = 0; i < 5; i++) drive(1'b1, 20000);
        idle(3);
        cur_tag = "R5 saturate low";
        for (int i = 0; i < 8; i++) drive(1'b1, -30000);
        idle(3);

        // R8 mid-stream reset clears history: first output equals input
        cur_tag = "R8 history after reset";
        do_reset(5'd0, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01, 2'b01, 2'b00);
        drive(1'b1, 41);
        drive(1'b1, 1);
        idle(3);

        // R9 comb with N = 8
        cur_tag = "R9 comb N8";
        do_reset(5'd8, 2'b01, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        burst(30, 1'b1);

        // R2 N = 0 with c = +1 cancels, c = -1 doubles
        cur_tag = "R2 zero delay cancel";
        do_reset(5'd0, 2'b01, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        burst(10, 1'b0);
        cur_tag = "R2 zero delay double";
        do_reset(5'd0, 2'b11, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        burst(10, 1'b0);

        // R2/R7 deepest tap reached through gaps
        cur_tag = "R2 delay 31 with gaps";
        do_reset(5'd31, 2'b11, 2'b01, 2'b00, 2'b00, 2'b01, 2'b00, 2'b00);
        burst(90, 1'b1);

        // R4 a0 negative and a0 negative-zero
        cur_tag = "R4 a0 negative";
        do_reset(5'd2, 2'b01, 2'b01, 2'b01, 2'b00, 2'b11, 2'b11, 2'b01);
        burst(20, 1'b1);
        cur_tag = "R1 a0 negative zero";
        do_reset(5'd3, 2'b00, 2'b01, 2'b11, 2'b01, 2'b10, 2'b01, 2'b11);
        burst(20, 1'b1);

        // R3/R4/R7 sweep over all ternary settings; R1 negative zero on odd digits
        cur_tag = "R3/R4/R7 sweep";
        for (int idx = 0; idx < 2187; idx++) begin
            logic [1:0] cd [7];
            int r;
            r = idx;
            for (int d = 0; d < 7; d++) begin
                case (r % 3)
                    0:       cd[d] = ((idx + d) % 2 == 1) ? 2'b10 : 2'b00;
                    1:       cd[d] = 2'b01;
                    default: cd[d] = 2'b11;
                endcase
                r = r / 3;
            end
            do_reset(5'(idx % 32), cd[0], cd[1], cd[2], cd[3], cd[4], cd[5], cd[6]);
            burst(10, 1'b1);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule